// File: doc/BRIEF.md
# Interlaced Field Read Address Generator

This block drives the address side of a bus-master read DMA that pulls an interlaced picture out of system memory one 32-bit word at a time. Software programs two field start addresses (one used for odd fields, one for even fields), a line stride, a count of lines per field and a count of bytes per line. A one-cycle field-start pulse, qualified by a parity flag, selects the matching start address and begins the walk. The walk goes word by word along a line, then jumps by the stride to the next line, until the programmed number of lines has been read.

The stride is independent of the bytes fetched per line. This lets the block read a rectangular window out of a wider frame buffer. Each word is offered on a valid/grant handshake, and only while the downstream FIFO reports space. A short final word of a line carries byte enables for its valid bytes only. When the last word of the field is granted, a one-cycle done pulse follows, and the generator stays idle until the next field start. A new field start in the middle of a field abandons the current walk at once.

Top module: `field_dma_addr_gen`

## Requirements
- R1: On a field-start pulse with `fld_odd`=1 the first request address is `cfg_base_odd`; with `fld_odd`=0 it is `cfg_base_even`. The first request is offered in the cycle after the pulse.
- R2: Line n of a field (counting from 0) starts at base + n × (`cfg_pitch` with its two low bits forced to zero), wrapping modulo 2^32.
- R3: A field issues exactly `cfg_lines` lines of requests.
- R4: Each line issues ceil(`cfg_bytes`/4) granted words at consecutive addresses, line start + 4·k for k = 0, 1, ….
- R5: `req_be` bit i enables the byte at address offset i. It is 4'hF on every word except the last word of a line when `cfg_bytes` mod 4 = r ≠ 0, where it is (2^r − 1): 4'h1, 4'h3 or 4'h7.
- R6: `req_valid` is 0 in every cycle in which `fifo_full` is 1. An offered request keeps its address and enables until it is granted.
- R7: `field_done` is high for exactly one cycle, the cycle after the last word of the last line is granted. In that cycle `busy` is 0, and no request is offered until the next field start.
- R8: A field-start pulse while a field is running takes priority over a grant in the same cycle. It restarts the walk from the base of the new parity, and the abandoned field produces no `field_done`.
- R9: When `cfg_lines` or `cfg_bytes` is 0, a field start produces no request, and `field_done` pulses in the cycle after the start.
- R10: `cfg_pitch_err` is 1 exactly when either of the two low bits of `cfg_pitch` is 1.
- R11: After reset, `busy`, `req_valid` and `field_done` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cfg_base_odd | input | ADDR_W | Start address used for odd fields |
| cfg_base_even | input | ADDR_W | Start address used for even fields |
| cfg_pitch | input | ADDR_W | Distance between consecutive line starts |
| cfg_lines | input | LINE_W | Lines per field |
| cfg_bytes | input | BYTE_W | Bytes fetched per line |
| fld_start | input | 1 | One-cycle field start pulse |
| fld_odd | input | 1 | Parity of the field being started (1 = odd) |
| fifo_full | input | 1 | Downstream FIFO has no space |
| req_grant | input | 1 | Request accepted by the bus side |
| req_valid | output | 1 | Word request offered |
| req_addr | output | ADDR_W | Word address of the request |
| req_be | output | 4 | Byte enables of the request |
| busy | output | 1 | A field walk is in progress |
| field_done | output | 1 | One-cycle pulse after the final word of a field |
| cfg_pitch_err | output | 1 | Stride is not word aligned |

## Verification
A wrong word counter shows in the very next granted address: that address skips or repeats four bytes. A wrong line counter or stride shows at the first word of the following line. A wrong terminal count shows either as a request beyond the expected total, or as a `field_done` that arrives one or more cycles early or late. The bench sweeps every small combination of parity, line count, byte count and aligned or misaligned stride under several grant and FIFO-full patterns. It compares each granted address and enable pattern against an arithmetic formula, so any such fault is seen at the first handshake it affects.

// File: rtl/fdag_pkg.sv
package fdag_pkg;

  typedef enum logic [0:0] {
    ST_IDLE = 1'b0,
    ST_RUN  = 1'b1
  } fdag_state_e;

  // Number of 32-bit words needed to cover a byte count.
  function automatic logic [31:0] words_for_bytes(input logic [31:0] nbytes);
    return (nbytes + 32'd3) >> 2;
  endfunction

  // Enables for the last word of a line, given the byte count's low bits.
  function automatic logic [3:0] tail_enables(input logic [1:0] rem);
    logic [3:0] be;
    case (rem)
      2'd1:    be = 4'b0001;
      2'd2:    be = 4'b0011;
      2'd3:    be = 4'b0111;
      default: be = 4'b1111;
    endcase
    return be;
  endfunction

  // Stride with the low two bits dropped.
  function automatic logic [31:0] aligned_stride(input logic [31:0] p);
    return {p[31:2], 2'b00};
  endfunction

endpackage

// File: rtl/fdag_line_walker.sv
module fdag_line_walker #(
  parameter int ADDR_W = 32,
  parameter int LINE_W = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [ADDR_W-1:0] base,
  input  logic              advance,
  input  logic [ADDR_W-1:0] stride,
  input  logic [LINE_W-1:0] lines,
  output logic [ADDR_W-1:0] line_addr,
  output logic [LINE_W-1:0] line_idx,
  output logic              last_line
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      line_addr <= '0;
      line_idx  <= '0;
    end else if (load) begin
      line_addr <= base;
      line_idx  <= '0;
    end else if (advance) begin
      line_addr <= line_addr + stride;
      line_idx  <= line_idx + LINE_W'(1);
    end
  end

  assign last_line = (line_idx == lines - LINE_W'(1));

endmodule

// File: rtl/fdag_word_walker.sv
module fdag_word_walker #(
  parameter int BYTE_W = 14
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clear,
  input  logic              step,
  input  logic [BYTE_W-1:0] nbytes,
  output logic [BYTE_W-1:0] word_idx,
  output logic [BYTE_W-1:0] words_per_line,
  output logic              last_word,
  output logic [3:0]        be
);

  assign words_per_line = BYTE_W'(fdag_pkg::words_for_bytes(32'(nbytes)));
  assign last_word      = (word_idx == words_per_line - BYTE_W'(1));
  assign be             = last_word ? fdag_pkg::tail_enables(nbytes[1:0]) : 4'hF;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      word_idx <= '0;
    end else if (clear) begin
      word_idx <= '0;
    end else if (step) begin
      word_idx <= word_idx + BYTE_W'(1);
    end
  end

endmodule

// File: rtl/field_dma_addr_gen.sv
module field_dma_addr_gen #(
  parameter int ADDR_W = 32,
  parameter int LINE_W = 12,
  parameter int BYTE_W = 14
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] cfg_base_odd,
  input  logic [ADDR_W-1:0] cfg_base_even,
  input  logic [ADDR_W-1:0] cfg_pitch,
  input  logic [LINE_W-1:0] cfg_lines,
  input  logic [BYTE_W-1:0] cfg_bytes,
  input  logic              fld_start,
  input  logic              fld_odd,
  input  logic              fifo_full,
  input  logic              req_grant,
  output logic              req_valid,
  output logic [ADDR_W-1:0] req_addr,
  output logic [3:0]        req_be,
  output logic              busy,
  output logic              field_done,
  output logic              cfg_pitch_err
);
  import fdag_pkg::*;

  localparam int OFS_W = BYTE_W + 2;

  fdag_state_e       state;
  logic              done_q;
  logic [ADDR_W-1:0] sel_base;
  logic [ADDR_W-1:0] stride;
  logic [ADDR_W-1:0] line_addr;
  logic [LINE_W-1:0] line_idx;
  logic              last_line;
  logic [BYTE_W-1:0] word_idx;
  logic [BYTE_W-1:0] wpl;
  logic              last_word;
  logic [3:0]        be;
  logic              empty_field;

  // Named internal events
  logic handshake;
  logic ev_word_step;
  logic ev_line_adv;
  logic ev_field_end;
  logic ev_restart;

  assign sel_base     = fld_odd ? cfg_base_odd : cfg_base_even;
  assign stride       = ADDR_W'(aligned_stride(32'(cfg_pitch)));
  assign empty_field  = (cfg_lines == '0) || (cfg_bytes == '0);

  assign busy         = (state == ST_RUN);
  assign req_valid    = busy && !fifo_full;
  assign handshake    = req_valid && req_grant;
  assign ev_restart   = fld_start;
  assign ev_word_step = handshake && !last_word && !fld_start;
  assign ev_line_adv  = handshake && last_word && !last_line && !fld_start;
  assign ev_field_end = handshake && last_word && last_line && !fld_start;

  fdag_line_walker #(
    .ADDR_W (ADDR_W),
    .LINE_W (LINE_W)
  ) u_lines (
    .clk       (clk),
    .rst_n     (rst_n),
    .load      (ev_restart),
    .base      (sel_base),
    .advance   (ev_line_adv),
    .stride    (stride),
    .lines     (cfg_lines),
    .line_addr (line_addr),
    .line_idx  (line_idx),
    .last_line (last_line)
  );

  fdag_word_walker #(
    .BYTE_W (BYTE_W)
  ) u_words (
    .clk            (clk),
    .rst_n          (rst_n),
    .clear          (ev_restart || ev_line_adv),
    .step           (ev_word_step),
    .nbytes         (cfg_bytes),
    .word_idx       (word_idx),
    .words_per_line (wpl),
    .last_word      (last_word),
    .be             (be)
  );

  assign req_addr      = line_addr + ADDR_W'({word_idx, 2'b00});
  assign req_be        = be;
  assign field_done    = done_q;
  assign cfg_pitch_err = |cfg_pitch[1:0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state  <= ST_IDLE;
      done_q <= 1'b0;
    end else if (ev_restart) begin
      state  <= empty_field ? ST_IDLE : ST_RUN;
      done_q <= empty_field;
    end else if (ev_field_end) begin
      state  <= ST_IDLE;
      done_q <= 1'b1;
    end else begin
      done_q <= 1'b0;
    end
  end

  // ---------------- assertions ----------------
  a_r6_no_req_when_full: assert property (@(posedge clk) disable iff (!rst_n)
    fifo_full |-> !req_valid);

  a_r6_hold_until_grant: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !req_grant && !fld_start) |=>
      (busy && req_addr == $past(req_addr) && req_be == $past(req_be)));

  a_r7_done_single: assert property (@(posedge clk) disable iff (!rst_n)
    field_done |=> !field_done);

  a_r7_idle_no_req: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !req_valid);

  a_r7_done_idle: assert property (@(posedge clk) disable iff (!rst_n)
    field_done |-> !busy);

  a_r1_first_addr: assert property (@(posedge clk) disable iff (!rst_n)
    fld_start |=> (!busy ||
      req_addr == ($past(fld_odd) ? $past(cfg_base_odd) : $past(cfg_base_even))));

  a_r5_low_byte_on: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |-> (req_be[0] && $countones(req_be + 4'd1) <= 1));

  a_r3_line_in_range: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> (line_idx < cfg_lines));

  a_r4_word_in_range: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> (word_idx < wpl));

endmodule

// File: tb/tb_field_dma_addr_gen.sv
`timescale 1ns/1ps
module tb_field_dma_addr_gen;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] cfg_base_odd = 32'h1000_0000;
  logic [31:0] cfg_base_even = 32'h2000_0800;
  logic [31:0] cfg_pitch = 32'h40;
  logic [11:0] cfg_lines = '0;
  logic [13:0] cfg_bytes = '0;
  logic        fld_start = 1'b0;
  logic        fld_odd = 1'b0;
  logic        fifo_full = 1'b0;
  logic        req_grant = 1'b0;
  logic        req_valid;
  logic [31:0] req_addr;
  logic [3:0]  req_be;
  logic        busy;
  logic        field_done;
  logic        cfg_pitch_err;

  int checks = 0;
  int failures = 0;
  bit finished = 0;

  always #2.5 clk = ~clk;

  field_dma_addr_gen dut (
    .clk(clk), .rst_n(rst_n),
    .cfg_base_odd(cfg_base_odd), .cfg_base_even(cfg_base_even),
    .cfg_pitch(cfg_pitch), .cfg_lines(cfg_lines), .cfg_bytes(cfg_bytes),
    .fld_start(fld_start), .fld_odd(fld_odd),
    .fifo_full(fifo_full), .req_grant(req_grant),
    .req_valid(req_valid), .req_addr(req_addr), .req_be(req_be),
    .busy(busy), .field_done(field_done), .cfg_pitch_err(cfg_pitch_err)
  );

  task automatic check(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] exp_addr(input logic [31:0] base, input int ln,
                                           input int wd);
    logic [31:0] step;
    step = cfg_pitch - (cfg_pitch % 4);
    return base + step * ln + 4 * wd;
  endfunction

  function automatic logic [3:0] exp_be(input int wd, input int nwords, input int nb);
    int r;
    r = nb % 4;
    if (wd == nwords - 1 && r != 0) return 4'((1 << r) - 1);
    return 4'hF;
  endfunction

  // Runs one complete field and checks every handshake.
  task automatic run_field(input bit odd, input int lines, input int nbytes, input int mode);
    int nwords, total, idx, cyc;
    bit last_taken;
    logic [31:0] base;
    nwords = (nbytes + 3) / 4;
    total = lines * nwords;
    base = odd ? cfg_base_odd : cfg_base_even;
    cfg_lines = 12'(lines);
    cfg_bytes = 14'(nbytes);
    @(negedge clk);
    fld_start = 1'b1; fld_odd = odd; req_grant = 1'b0; fifo_full = 1'b0;
    @(negedge clk);
    fld_start = 1'b0;
    idx = 0; cyc = 0;
    last_taken = (total == 0);
    forever begin
      fifo_full = (mode == 2) && (cyc % 5 == 1);
      req_grant = (mode == 0) ? 1'b1 : (cyc % 3 != 0);
      #1;
      if (last_taken) begin
        // R7 / R9: done one cycle after last grant (or after start when empty)
        check(field_done && !busy && !req_valid, "R7/R9 done pulse",
              {29'd0, field_done, busy, req_valid}, 32'h4);
        break;
      end
      check(!field_done, "R7 no early done", {31'd0, field_done}, 32'd0);
      if (fifo_full) check(!req_valid, "R6 blocked when full", {31'd0, req_valid}, 32'd0);
      if (cyc == 0 && total > 0)
        check(req_valid && req_addr == base, "R1 first address", req_addr, base);
      if (req_valid && req_grant) begin
        if (idx >= total) begin
          check(1'b0, "R3 extra request", 32'(idx), 32'(total));
        end else begin
          check(req_addr == exp_addr(base, idx / nwords, idx % nwords),
                "R2/R4 address", req_addr, exp_addr(base, idx / nwords, idx % nwords));
          check(req_be == exp_be(idx % nwords, nwords, nbytes), "R5 byte enables",
                32'(req_be), 32'(exp_be(idx % nwords, nwords, nbytes)));
          idx++;
          if (idx == total) last_taken = 1;
        end
      end
      cyc++;
      if (cyc > 500) begin
        check(1'b0, "R3 field never completed", 32'(idx), 32'(total));
        break;
      end
      @(negedge clk);
    end
    req_grant = 1'b1; fifo_full = 1'b0;
    @(negedge clk); #1;
    check(!busy && !req_valid && !field_done, "R7 idle after done",
          {29'd0, busy, req_valid, field_done}, 32'd0);
    req_grant = 1'b0;
  endtask

  initial begin
    #1_000_000;
    if (!finished) begin
      failures++; checks++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    #1;
    check(!busy && !req_valid && !field_done, "R11 reset state",
          {29'd0, busy, req_valid, field_done}, 32'd0);
    rst_n = 1'b1;
    @(negedge clk); #1;
    check(!busy && !req_valid, "R11 idle after release", {30'd0, busy, req_valid}, 32'd0);

    // R10 alignment flag
    for (int p = 0; p < 8; p++) begin
      cfg_pitch = 32'h40 + 32'(p);
      #1;
      check(cfg_pitch_err == (p % 4 != 0), "R10 pitch flag", {31'd0, cfg_pitch_err},
            {31'd0, (p % 4 != 0)});
    end

    // Sweep: parity x lines x bytes x aligned/misaligned stride
    for (int pv = 0; pv < 2; pv++) begin
      cfg_pitch = (pv == 0) ? 32'h40 : 32'h43;
      for (int od = 0; od < 2; od++)
        for (int ln = 0; ln < 4; ln++)
          for (int nb = 0; nb < 10; nb++)
            run_field(od[0], ln, nb, (ln + nb + pv) % 3);
    end

    // Stride wrapping past the top of the address space (R2)
    cfg_pitch = 32'h8000_0000;
    cfg_base_odd = 32'hC000_0000;
    run_field(1'b1, 3, 6, 1);
    cfg_base_odd = 32'h1000_0000;
    cfg_pitch = 32'h100;

    // R8: abort an odd field mid-way, restart as even
    cfg_lines = 12'd3; cfg_bytes = 14'd8;
    @(negedge clk);
    fld_start = 1'b1; fld_odd = 1'b1; req_grant = 1'b0; fifo_full = 1'b0;
    @(negedge clk);
    fld_start = 1'b0; req_grant = 1'b1;
    for (int k = 0; k < 3; k++) begin
      #1;
      check(req_valid && req_addr == exp_addr(cfg_base_odd, k / 2, k % 2),
            "R8 pre-abort address", req_addr, exp_addr(cfg_base_odd, k / 2, k % 2));
      @(negedge clk);
    end
    // restart with a grant present in the same cycle: start wins
    fld_start = 1'b1; fld_odd = 1'b0; req_grant = 1'b1;
    @(negedge clk);
    fld_start = 1'b0; req_grant = 1'b0;
    #1;
    check(busy && req_addr == cfg_base_even && !field_done, "R8 restart at even base",
          req_addr, cfg_base_even);
    run_field(1'b0, 3, 8, 2);

    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule